// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a two-bank SDR SDRAM between reset and the moment the memory can accept normal traffic. Once reset is released it keeps clock enable and the data mask high and sends only idle commands for a settling interval of at least 200 µs. The interval is converted to clock cycles from a clock-frequency parameter. It then closes every bank with one precharge-all command. Next it programs the mode register with an opcode taken from an input port and issues a burst of auto refresh commands. The mode load and the refresh burst can run in either order, chosen by a parameter.

Each command is followed by idle cycles that honour a parameterized spacing: row precharge time after the precharge, row cycle time after each refresh, and mode-load delay after the mode load. When the last command's spacing has elapsed, a completion flag rises and stays high until the next reset. A memory controller holds its own command logic off until that flag is seen. All command pins are registered, so they change only on the clock edge.

Top module: `sdram_power_init`

## Requirements
- R1: While reset is asserted the pins show csN=0, rasN=1, casN=1, weN=1, addr=0, cke=1, dqm=1 and initDone=0. From reset release until initDone, cke and dqm stay 1.
- R2: After reset release, at least CLK_MHZ*WAIT_US clock cycles carry only idle commands (NOP: csN=0 with rasN, casN, weN all 1; or deselect: csN=1) before any other command appears.
- R3: The first non-idle command is precharge-all: csN=0, rasN=0, casN=1, weN=0, with addr bit 10 set to 1.
- R4: The mode load is encoded as csN, rasN, casN and weN all 0, with addr equal to the modeOpcode input.
- R5: Exactly REF_NUM auto refresh commands (csN=0, rasN=0, casN=0, weN=1, cke=1) are issued. REF_NUM defaults to 8 and must be at least 8.
- R6: With MODE_FIRST=1 the order is precharge, mode load, refreshes. With MODE_FIRST=0 the order is precharge, refreshes, mode load.
- R7: The next command never comes sooner than TRP_CYC cycles after a precharge, TRC_CYC cycles after a refresh, or TMRD_CYC cycles after a mode load. Each spacing is raised to at least 2.
- R8: initDone rises no earlier than the spacing of the last command after that command. It then stays 1 and no further non-idle command is issued until reset.
- R9: A reset at any point clears initDone and restarts the whole sequence from the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeOpcode | input | ADDR_W | Value written to the mode register |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | 1 | Data mask |
| addr | output | ADDR_W | Address bus A0 upward |
| initDone | output | 1 | Initialization complete, sticky until reset |

## Verification
The embedded assertions check several rules on every cycle: no command before the wait count, the minimum spacing from the previous command, at most one command strobe per cycle, the refresh total at completion, the position of the mode load relative to the refreshes, and the flag's stickiness with silent pins once initialization is complete. Other properties can only be shown by the bench's scenarios, which decode the pins of two instances built with opposite orderings. These are the exact command order, the opcode and bit-10 values on the address bus, the reset pin state, and a restart after a reset in the middle of the refresh burst.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_PRE,
    ST_MODE,
    ST_REF,
    ST_GAP,
    ST_DONE
  } init_state_t;

  typedef struct packed {
    logic doPre;
    logic doMode;
    logic doRefresh;
    logic markDone;
  } init_strobe_t;

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int WAIT_CYC   = 20000,
  parameter int TRP_CYC    = 3,
  parameter int TRC_CYC    = 7,
  parameter int TMRD_CYC   = 2,
  parameter int REF_NUM    = 8,
  parameter bit MODE_FIRST = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  output init_strobe_t strb
);

  localparam int MAX_A   = (WAIT_CYC > TRP_CYC) ? WAIT_CYC : TRP_CYC;
  localparam int MAX_B   = (TRC_CYC > TMRD_CYC) ? TRC_CYC : TMRD_CYC;
  localparam int CNT_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int REF_W   = $clog2(REF_NUM + 1);

  localparam init_state_t AFTER_PRE  = MODE_FIRST ? ST_MODE : ST_REF;
  localparam init_state_t AFTER_MODE = MODE_FIRST ? ST_REF  : ST_DONE;
  localparam init_state_t AFTER_REFS = MODE_FIRST ? ST_DONE : ST_MODE;

  init_state_t state, resume;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] refCnt;
  logic modeSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      resume   <= ST_PRE;
      cnt      <= CNT_W'(WAIT_CYC);
      refCnt   <= '0;
      modeSeen <= 1'b0;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (cnt == CNT_W'(1)) state <= ST_PRE;
          else cnt <= cnt - 1'b1;
        end
        ST_PRE: begin
          cnt    <= CNT_W'(TRP_CYC - 1);
          resume <= AFTER_PRE;
          state  <= ST_GAP;
        end
        ST_MODE: begin
          cnt      <= CNT_W'(TMRD_CYC - 1);
          resume   <= AFTER_MODE;
          modeSeen <= 1'b1;
          state    <= ST_GAP;
        end
        ST_REF: begin
          cnt    <= CNT_W'(TRC_CYC - 1);
          refCnt <= refCnt + 1'b1;
          resume <= (refCnt == REF_W'(REF_NUM - 1)) ? AFTER_REFS : ST_REF;
          state  <= ST_GAP;
        end
        ST_GAP: begin
          if (cnt == CNT_W'(1)) state <= resume;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    strb.doPre     = (state == ST_PRE);
    strb.doMode    = (state == ST_MODE);
    strb.doRefresh = (state == ST_REF);
    strb.markDone  = (state == ST_DONE);
  end

  // R7
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doPre, strb.doMode, strb.doRefresh, strb.markDone}));

  // R5
  ref_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.markDone |-> (refCnt == REF_W'(REF_NUM)));

  // R6
  mode_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doRefresh |-> (modeSeen == MODE_FIRST));

endmodule

// File: rtl/sdram_init_cmd_path.sv
module sdram_init_cmd_path
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PRE_ALL_BIT = 10,
  parameter int WAIT_CYC    = 20000,
  parameter int TRP_CYC     = 3,
  parameter int TRC_CYC     = 7,
  parameter int TMRD_CYC    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  init_strobe_t      strb,
  input  logic [ADDR_W-1:0] modeOpcode,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              cke,
  output logic              dqm,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << PRE_ALL_BIT;
  localparam int GAP_MAX = (TRP_CYC > TRC_CYC)
                         ? ((TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC)
                         : ((TRC_CYC > TMRD_CYC) ? TRC_CYC : TMRD_CYC);
  localparam int GAP_W  = $clog2(GAP_MAX + 1);
  localparam int WAIT_W = $clog2(WAIT_CYC + 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {csN, rasN, casN, weN} <= 4'b0111;
      addr     <= '0;
      cke      <= 1'b1;
      dqm      <= 1'b1;
      initDone <= 1'b0;
    end else begin
      {csN, rasN, casN, weN} <= 4'b0111;
      addr <= '0;
      cke  <= 1'b1;
      dqm  <= 1'b1;
      if (strb.doPre) begin
        {csN, rasN, casN, weN} <= 4'b0010;
        addr <= PRE_ADDR;
      end
      if (strb.doMode) begin
        {csN, rasN, casN, weN} <= 4'b0000;
        addr <= modeOpcode;
      end
      if (strb.doRefresh) begin
        {csN, rasN, casN, weN} <= 4'b0001;
      end
      if (strb.markDone) initDone <= 1'b1;
    end
  end

  // Observation state for the timing checks below.
  logic [WAIT_W-1:0] sinceReset;
  logic [GAP_W-1:0]  sinceCmd;
  logic [GAP_W-1:0]  needGap;
  logic              anyCmd;
  logic              issue;

  assign issue = strb.doPre | strb.doMode | strb.doRefresh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceReset <= '0;
      sinceCmd   <= '0;
      needGap    <= '0;
      anyCmd     <= 1'b0;
    end else begin
      if (sinceReset != WAIT_W'(WAIT_CYC)) sinceReset <= sinceReset + 1'b1;
      if (issue) begin
        anyCmd   <= 1'b1;
        sinceCmd <= GAP_W'(1);
        if (strb.doPre)     needGap <= GAP_W'(TRP_CYC);
        if (strb.doMode)    needGap <= GAP_W'(TMRD_CYC);
        if (strb.doRefresh) needGap <= GAP_W'(TRC_CYC);
      end else if (sinceCmd != GAP_W'(GAP_MAX)) begin
        sinceCmd <= sinceCmd + 1'b1;
      end
    end
  end

  // R2
  wait_before_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> (sinceReset == WAIT_W'(WAIT_CYC)));

  // R7
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((issue || strb.markDone) && anyCmd) |-> (sinceCmd >= needGap));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R8
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (csN || (rasN && casN && weN)));

endmodule

// File: rtl/sdram_power_init.sv
module sdram_power_init
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int WAIT_US    = 200,
  parameter int ADDR_W     = 12,
  parameter int TRP_CYC    = 3,
  parameter int TRC_CYC    = 7,
  parameter int TMRD_CYC   = 2,
  parameter int REF_NUM    = 8,
  parameter bit MODE_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] modeOpcode,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              cke,
  output logic              dqm,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam int WAIT_RAW = CLK_MHZ * WAIT_US;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int TRP_EFF  = (TRP_CYC  < 2) ? 2 : TRP_CYC;
  localparam int TRC_EFF  = (TRC_CYC  < 2) ? 2 : TRC_CYC;
  localparam int TMRD_EFF = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int REF_EFF  = (REF_NUM  < 8) ? 8 : REF_NUM;

  init_strobe_t strb;

  sdram_init_ctrl #(
    .WAIT_CYC  (WAIT_CYC),
    .TRP_CYC   (TRP_EFF),
    .TRC_CYC   (TRC_EFF),
    .TMRD_CYC  (TMRD_EFF),
    .REF_NUM   (REF_EFF),
    .MODE_FIRST(MODE_FIRST)
  ) uCtrl (
    .clk (clk),
    .rstN(rstN),
    .strb(strb)
  );

  sdram_init_cmd_path #(
    .ADDR_W     (ADDR_W),
    .PRE_ALL_BIT(10),
    .WAIT_CYC   (WAIT_CYC),
    .TRP_CYC    (TRP_EFF),
    .TRC_CYC    (TRC_EFF),
    .TMRD_CYC   (TMRD_EFF)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .modeOpcode(modeOpcode),
    .csN       (csN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .cke       (cke),
    .dqm       (dqm),
    .addr      (addr),
    .initDone  (initDone)
  );

endmodule

// File: tb/sim_sdram_power_init.sv
module sim_sdram_power_init;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYC   = 200;   // CLK_MHZ=1, WAIT_US=200
  localparam int TRP        = 3;
  localparam int TRC        = 5;
  localparam int TMRD       = 2;
  localparam int NCMD       = 10;
  // command codes: 1 precharge-all, 2 mode load, 3 refresh
  localparam int EXP_SEQ [2][NCMD] = '{
    '{1, 2, 3, 3, 3, 3, 3, 3, 3, 3},
    '{1, 3, 3, 3, 3, 3, 3, 3, 3, 2}
  };
  localparam logic [11:0] OPC [2] = '{12'h232, 12'h0A7};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] csN, rasN, casN, weN, cke, dqm, initDone;
  logic [11:0] addr [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_power_init #(.CLK_MHZ(1), .WAIT_US(200), .TRP_CYC(TRP), .TRC_CYC(TRC),
                     .TMRD_CYC(TMRD), .REF_NUM(8), .MODE_FIRST(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .modeOpcode(OPC[0]),
    .csN(csN[0]), .rasN(rasN[0]), .casN(casN[0]), .weN(weN[0]),
    .cke(cke[0]), .dqm(dqm[0]), .addr(addr[0]), .initDone(initDone[0]));

  sdram_power_init #(.CLK_MHZ(1), .WAIT_US(200), .TRP_CYC(TRP), .TRC_CYC(TRC),
                     .TMRD_CYC(TMRD), .REF_NUM(8), .MODE_FIRST(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .modeOpcode(OPC[1]),
    .csN(csN[1]), .rasN(rasN[1]), .casN(casN[1]), .weN(weN[1]),
    .cke(cke[1]), .dqm(dqm[1]), .addr(addr[1]), .initDone(initDone[1]));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int edgeCnt = 0;
  int nCmd [2];
  int cmdType [2][16];
  int cmdCyc [2][16];
  logic [11:0] cmdAddr [2][16];
  int doneCyc [2];
  bit pinBad [2];

  always @(posedge clk) begin
    if (!rstN) edgeCnt <= 0;
    else edgeCnt <= edgeCnt + 1;
  end

  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 2; i++) begin
        int code;
        code = 0;
        if (!csN[i]) begin
          if (!rasN[i] && casN[i] && !weN[i]) code = 1;
          else if (!rasN[i] && !casN[i] && !weN[i]) code = 2;
          else if (!rasN[i] && !casN[i] && weN[i]) code = 3;
          else if (!(rasN[i] && casN[i] && weN[i])) code = 9;
        end
        if (!initDone[i] && (!cke[i] || !dqm[i])) pinBad[i] = 1;
        if (code == 3 && !cke[i]) pinBad[i] = 1;
        if (code != 0 && nCmd[i] < 16) begin
          cmdType[i][nCmd[i]] = code;
          cmdCyc[i][nCmd[i]]  = edgeCnt;
          cmdAddr[i][nCmd[i]] = addr[i];
          nCmd[i]++;
        end
        if (initDone[i] && doneCyc[i] < 0) doneCyc[i] = edgeCnt;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gapOf(input int code);
    return (code == 1) ? TRP : (code == 2) ? TMRD : TRC;
  endfunction

  task automatic clearRecords();
    for (int i = 0; i < 2; i++) begin
      nCmd[i] = 0;
      doneCyc[i] = -1;
      pinBad[i] = 0;
    end
  endtask

  task automatic checkReset();
    for (int i = 0; i < 2; i++) begin
      chk({csN[i], rasN[i], casN[i], weN[i]} == 4'b0111, "R1", "reset command pins",
          {csN[i], rasN[i], casN[i], weN[i]}, 4'b0111);
      chk(addr[i] == 12'h000 && cke[i] && dqm[i], "R1", "reset addr/cke/dqm",
          {addr[i], cke[i], dqm[i]}, 3);
      chk(!initDone[i], "R9", "initDone low in reset", initDone[i], 0);
    end
  endtask

  task automatic checkRun();
    for (int i = 0; i < 2; i++) begin
      chk(nCmd[i] == NCMD, "R5", "command total incl. 8 refreshes", nCmd[i], NCMD);
      chk(cmdCyc[i][0] - 1 >= WAIT_CYC, "R2", "idle cycles before first command",
          cmdCyc[i][0] - 1, WAIT_CYC);
      chk(cmdAddr[i][0][10] == 1'b1, "R3", "precharge A10", cmdAddr[i][0][10], 1);
      for (int k = 0; k < NCMD; k++) begin
        if (k < nCmd[i]) begin
          chk(cmdType[i][k] == EXP_SEQ[i][k], "R6", "command order",
              cmdType[i][k], EXP_SEQ[i][k]);
          if (k > 0)
            chk(cmdCyc[i][k] - cmdCyc[i][k-1] >= gapOf(cmdType[i][k-1]), "R7",
                "spacing", cmdCyc[i][k] - cmdCyc[i][k-1], gapOf(cmdType[i][k-1]));
          if (cmdType[i][k] == 2)
            chk(cmdAddr[i][k] == OPC[i], "R4", "mode opcode on addr",
                cmdAddr[i][k], OPC[i]);
        end
      end
      chk(doneCyc[i] >= 0, "R8", "initDone raised", doneCyc[i], 1);
      if (nCmd[i] >= NCMD && doneCyc[i] >= 0)
        chk(doneCyc[i] - cmdCyc[i][NCMD-1] >= gapOf(cmdType[i][NCMD-1]), "R8",
            "done after last spacing", doneCyc[i] - cmdCyc[i][NCMD-1],
            gapOf(cmdType[i][NCMD-1]));
      chk(initDone[i], "R8", "initDone still high", initDone[i], 1);
      chk(!pinBad[i], "R1", "cke/dqm high until done", pinBad[i], 0);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clearRecords();
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    // full run for both orderings, then extra idle time for R8 silence
    repeat (WAIT_CYC + 120) @(negedge clk);
    checkRun();
    // reset in the middle of the refresh burst: R9
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkReset();
    clearRecords();
    rstN = 1'b1;
    repeat (WAIT_CYC + 12) @(negedge clk);
    for (int i = 0; i < 2; i++)
      chk(!initDone[i] && nCmd[i] > 1, "R9", "mid-sequence before reset",
          initDone[i], 0);
    rstN = 1'b0;
    @(negedge clk);
    checkReset();
    clearRecords();
    rstN = 1'b1;
    repeat (WAIT_CYC + 120) @(negedge clk);
    checkRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule